// File: doc/BRIEF.md
# SCSI Controller Interrupt Status Unit

This unit owns the interrupt request line of a SCSI bus controller together with three byte-wide readable registers: the status byte, the interrupt-cause byte and the sequence-step value. Other parts of the controller signal what happened through one-cycle strobes. A generic event load covers command done, bus service and disconnect. The remaining strobes are a bus-reset command, enable-selection and disable-selection commands, and a completion report from the target side that carries a status byte. The interrupt line is a level output and always equals the pending bit held in the status byte.

The host acknowledges an interrupt by reading the cause register. During the read cycle it sees the value the register held before the read. The read then clears the cause, the terminal-count bit, the pending bit and the interrupt, and loads the sequence step with its "command done" code. A completion that arrives while an interrupt is still pending is not reported at once. It is parked in a single slot and replayed by the read that acknowledges the earlier interrupt. On a report, a one-cycle pulse tells the data path to zero its FIFO-flags and its transfer-count bytes. The completion's status byte is kept in a register that the response path reads later.

Top module: `scsi_intr_status`

## Requirements
- R1: After a synchronous active-low reset the status, cause, sequence step and held completion byte are all zero, `irq` is low, no completion is parked, and `xfer_clr` is low. `irq` always equals status bit 7, the pending bit. Setting that bit when it is already set, or clearing it when it is already clear, leaves `irq` unchanged.
- R2: A cycle with `cause_rd` high shows the previous cause value on `cause`. At the next edge the cause becomes 0x00, status bit 4 (terminal count) and bit 7 are cleared, the other status bits are kept, and `seq` becomes 4 (command done).
- R3: A completion request that sees the pending bit set changes no visible register. Its status byte is parked and a parked flag is set, overwriting any earlier parked completion.
- R4: A cause read taken while a completion is parked reports that parked completion in the same update and clears the parked flag. A later read finds nothing to replay.
- R5: Reporting a completion sets status to 0x93 (phase code 3 in bits 2:0, terminal count in bit 4, pending in bit 7) and cause to 0x10 (bus service). It sets `seq` to 0, stores the completion's status byte on `cpl_held`, and pulses `xfer_clr` high for exactly the cycle after the update.
- R6: A bus-reset command loads cause 0x80. It raises the pending bit only when `rpt_dis` is low and otherwise leaves the bit as it was.
- R7: A disable-selection command clears the cause and raises the pending bit. An enable-selection command clears the cause and leaves the pending bit as it was.
- R8: Strobes in the same cycle are applied in this order: cause read (with any replay), then completion, then event load, then bus reset, then enable-selection, then disable-selection. A completion that comes with a read is reported at once, unless the read replays a parked completion, in which case the new one is parked.
- R9: An event load writes `evt_stat` into status bits 6:0, `evt_cause` into the cause and `evt_seq` into `seq`. It sets the pending bit when `evt_raise` is high and otherwise keeps it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cause_rd | input | 1 | Host read strobe of the cause register |
| cpl_req | input | 1 | Completion report from the target side |
| cpl_status | input | 8 | Status byte of that completion |
| evt_load | input | 1 | Generic event strobe (command done, bus service, disconnect) |
| evt_stat | input | 7 | Status bits 6:0 for the event |
| evt_cause | input | 8 | Cause value for the event |
| evt_seq | input | 3 | Sequence step for the event |
| evt_raise | input | 1 | Event raises the interrupt |
| busrst_cmd | input | 1 | Bus-reset command strobe |
| rpt_dis | input | 1 | Configuration bit that suppresses the bus-reset interrupt |
| selen_cmd | input | 1 | Enable-selection command strobe |
| seldis_cmd | input | 1 | Disable-selection command strobe |
| irq | output | 1 | Level interrupt request |
| status | output | 8 | Status register |
| cause | output | 8 | Interrupt-cause register |
| seq | output | 3 | Sequence-step register |
| cpl_held | output | 8 | Status byte of the last reported completion |
| xfer_clr | output | 1 | Pulse: zero FIFO flags and transfer counts |

## Verification
The bench goes after the replay path: a completion parked while the interrupt is high must come back on the next acknowledging read, and only once. A design that dropped it would leave the host without a completion, and one that failed to clear the flag would report it twice. The case of a read and a completion in the same cycle is driven both with and without a parked entry, because wrong ordering either loses the new completion or reports it over the replay. A sweep of bus-reset over the suppress bit and the prior interrupt level catches a design that lowers an already pending interrupt. Sweeps of event loads and completion bytes catch wrongly placed bits and a stale held byte.

// File: rtl/isu_pkg.sv
// Package: shared widths, bit positions and code values of the interrupt status unit.
// Assumes 8-bit registers with the pending bit at the top of the status byte.
package isu_pkg;
    localparam int BYTE_W   = 8;
    localparam int SEQ_W    = 3;
    localparam int INT_BIT  = 7;
    localparam int TC_BIT   = 4;
    localparam int LOW_W    = INT_BIT;

    localparam logic [2:0]        PHASE_STATUS  = 3'd3;
    localparam logic [BYTE_W-1:0] CAUSE_BUSSERV = 8'h10;
    localparam logic [BYTE_W-1:0] CAUSE_BUSRST  = 8'h80;
    localparam logic [SEQ_W-1:0]  SEQ_CMD_DONE  = 3'd4;

    localparam logic [BYTE_W-1:0] TC_MASK  = BYTE_W'(1) << TC_BIT;
    localparam logic [BYTE_W-1:0] INT_MASK = BYTE_W'(1) << INT_BIT;
    localparam logic [BYTE_W-1:0] REPORT_STATUS =
        TC_MASK | INT_MASK | BYTE_W'(PHASE_STATUS);

    typedef struct packed {
        logic [BYTE_W-1:0] stat;
        logic [BYTE_W-1:0] cause;
        logic [SEQ_W-1:0]  seq;
        logic [BYTE_W-1:0] held;
    } isu_regs_t;

    // Register image after a completion has been reported.
    function automatic isu_regs_t report_done(input logic [BYTE_W-1:0] sb);
        isu_regs_t r;
        r.stat  = REPORT_STATUS;
        r.cause = CAUSE_BUSSERV;
        r.seq   = '0;
        r.held  = sb;
        return r;
    endfunction
endpackage

// File: rtl/isu_defer_slot.sv
// Single-entry parking slot for a completion that arrived while an
// interrupt was pending. Assumes store and take may coincide; store wins.
module isu_defer_slot #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         store,
    input  logic [W-1:0] store_val,
    input  logic         take,
    output logic         pend,
    output logic [W-1:0] pend_val
);
    // Holds the parked flag and status byte; a new park overrides a take.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend     <= 1'b0;
            pend_val <= '0;
        end else if (store) begin
            pend     <= 1'b1;
            pend_val <= store_val;
        end else if (take) begin
            pend     <= 1'b0;
        end
    end

    p_store_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        store |=> pend && pend_val == $past(store_val));
    p_take_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        take && !store |=> !pend);
endmodule

// File: rtl/isu_next_state.sv
// Combinational next-value logic for the status, cause, sequence and held
// registers. Applies same-cycle strobes in a fixed order: read/replay,
// completion, event, bus reset, enable-selection, disable-selection.
module isu_next_state
    import isu_pkg::*;
(
    input  isu_regs_t          cur,
    input  logic               cause_rd,
    input  logic               cpl_req,
    input  logic [BYTE_W-1:0]  cpl_status,
    input  logic               evt_load,
    input  logic [LOW_W-1:0]   evt_stat,
    input  logic [BYTE_W-1:0]  evt_cause,
    input  logic [SEQ_W-1:0]   evt_seq,
    input  logic               evt_raise,
    input  logic               busrst_cmd,
    input  logic               rpt_dis,
    input  logic               selen_cmd,
    input  logic               seldis_cmd,
    input  logic               pend,
    input  logic [BYTE_W-1:0]  pend_val,
    output isu_regs_t          nxt,
    output logic               take,
    output logic               store,
    output logic               report
);
    // Folds every strobe of this cycle into the next register image.
    always_comb begin
        nxt    = cur;
        take   = 1'b0;
        store  = 1'b0;
        report = 1'b0;
        if (cause_rd) begin
            nxt.cause          = '0;
            nxt.stat[TC_BIT]   = 1'b0;
            nxt.stat[INT_BIT]  = 1'b0;
            nxt.seq            = SEQ_CMD_DONE;
            if (pend) begin
                nxt    = report_done(pend_val);
                take   = 1'b1;
                report = 1'b1;
            end
        end
        if (cpl_req) begin
            if (nxt.stat[INT_BIT]) begin
                store = 1'b1;
            end else begin
                nxt    = report_done(cpl_status);
                report = 1'b1;
            end
        end
        if (evt_load) begin
            nxt.stat[LOW_W-1:0] = evt_stat;
            nxt.cause           = evt_cause;
            nxt.seq             = evt_seq;
            if (evt_raise) nxt.stat[INT_BIT] = 1'b1;
        end
        if (busrst_cmd) begin
            nxt.cause = CAUSE_BUSRST;
            if (!rpt_dis) nxt.stat[INT_BIT] = 1'b1;
        end
        if (selen_cmd) nxt.cause = '0;
        if (seldis_cmd) begin
            nxt.cause         = '0;
            nxt.stat[INT_BIT] = 1'b1;
        end
    end
endmodule

// File: rtl/scsi_intr_status.sv
// Interrupt status unit: owns status, cause, sequence-step and held
// completion registers and the level interrupt. Assumes every strobe is a
// single-cycle pulse synchronous to clk.
module scsi_intr_status
    import isu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cause_rd,
    input  logic              cpl_req,
    input  logic [7:0]        cpl_status,
    input  logic              evt_load,
    input  logic [6:0]        evt_stat,
    input  logic [7:0]        evt_cause,
    input  logic [2:0]        evt_seq,
    input  logic              evt_raise,
    input  logic              busrst_cmd,
    input  logic              rpt_dis,
    input  logic              selen_cmd,
    input  logic              seldis_cmd,
    output logic              irq,
    output logic [7:0]        status,
    output logic [7:0]        cause,
    output logic [2:0]        seq,
    output logic [7:0]        cpl_held,
    output logic              xfer_clr
);
    isu_regs_t          regs_q, regs_d;
    logic               take, store, report;
    logic               pend;
    logic [BYTE_W-1:0]  pend_val;

    isu_next_state u_next (
        .cur        (regs_q),
        .cause_rd   (cause_rd),
        .cpl_req    (cpl_req),
        .cpl_status (cpl_status),
        .evt_load   (evt_load),
        .evt_stat   (evt_stat),
        .evt_cause  (evt_cause),
        .evt_seq    (evt_seq),
        .evt_raise  (evt_raise),
        .busrst_cmd (busrst_cmd),
        .rpt_dis    (rpt_dis),
        .selen_cmd  (selen_cmd),
        .seldis_cmd (seldis_cmd),
        .pend       (pend),
        .pend_val   (pend_val),
        .nxt        (regs_d),
        .take       (take),
        .store      (store),
        .report     (report)
    );

    isu_defer_slot #(.W(BYTE_W)) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .store     (store),
        .store_val (cpl_status),
        .take      (take),
        .pend      (pend),
        .pend_val  (pend_val)
    );

    // Registers the visible state and the one-cycle clear pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q   <= '0;
            xfer_clr <= 1'b0;
        end else begin
            regs_q   <= regs_d;
            xfer_clr <= report;
        end
    end

    assign status   = regs_q.stat;
    assign cause    = regs_q.cause;
    assign seq      = regs_q.seq;
    assign cpl_held = regs_q.held;
    assign irq      = regs_q.stat[INT_BIT];

    logic cmds_idle;
    assign cmds_idle = !evt_load && !busrst_cmd && !selen_cmd && !seldis_cmd;

    p_read_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cause_rd && !pend && !cpl_req && cmds_idle |=>
        cause == '0 && !irq && !status[TC_BIT] && seq == SEQ_CMD_DONE);
    p_park_keeps_regs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_req && irq && !cause_rd && cmds_idle |=>
        $stable(status) && $stable(cause) && $stable(cpl_held) && !xfer_clr);
    p_replay_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cause_rd && pend && !cpl_req && cmds_idle |=>
        irq && cause == CAUSE_BUSSERV && cpl_held == $past(pend_val) && xfer_clr);
    p_report_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_req && !irq && !cause_rd && cmds_idle |=>
        status == REPORT_STATUS && seq == '0 && cpl_held == $past(cpl_status) && xfer_clr);
    p_busrst_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busrst_cmd && !cause_rd && !cpl_req && !evt_load && !selen_cmd && !seldis_cmd |=>
        cause == CAUSE_BUSRST && irq == ($past(irq) || !$past(rpt_dis)));
    p_seldis_r7: assert property (@(posedge clk) disable iff (!rst_n)
        seldis_cmd |=> cause == '0 && irq);
    p_selen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        selen_cmd && !seldis_cmd && !cause_rd && !cpl_req && !evt_load && !busrst_cmd |=>
        cause == '0 && irq == $past(irq));
endmodule

// File: tb/scsi_intr_status_tb.sv
`timescale 1ns/1ps
module scsi_intr_status_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       cause_rd, cpl_req, evt_load, evt_raise;
    logic [7:0] cpl_status, evt_cause;
    logic [6:0] evt_stat;
    logic [2:0] evt_seq;
    logic       busrst_cmd, rpt_dis, selen_cmd, seldis_cmd;
    logic       irq, xfer_clr;
    logic [7:0] status, cause, cpl_held;
    logic [2:0] seq;
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    scsi_intr_status u_dut (
        .clk(clk), .rst_n(rst_n), .cause_rd(cause_rd), .cpl_req(cpl_req),
        .cpl_status(cpl_status), .evt_load(evt_load), .evt_stat(evt_stat),
        .evt_cause(evt_cause), .evt_seq(evt_seq), .evt_raise(evt_raise),
        .busrst_cmd(busrst_cmd), .rpt_dis(rpt_dis), .selen_cmd(selen_cmd),
        .seldis_cmd(seldis_cmd), .irq(irq), .status(status), .cause(cause),
        .seq(seq), .cpl_held(cpl_held), .xfer_clr(xfer_clr)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        cause_rd = 0; cpl_req = 0; evt_load = 0; evt_raise = 0;
        busrst_cmd = 0; selen_cmd = 0; seldis_cmd = 0;
    endtask

    // Inputs are set at a falling edge; this lets one rising edge pass and
    // returns at the next falling edge with the strobes dropped.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic do_read();
        cause_rd = 1; tick();
    endtask

    task automatic do_cpl(input logic [7:0] sb);
        cpl_req = 1; cpl_status = sb; tick();
    endtask

    task automatic regs(input string req, input int st, input int ca, input int sq,
                        input int hd, input int xc);
        chk(req, "status", status, st);
        chk(req, "cause", cause, ca);
        chk(req, "seq", seq, sq);
        chk(req, "held", cpl_held, hd);
        chk(req, "xfer_clr", xfer_clr, xc);
        chk(req, "irq", irq, (st >> 7) & 1);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        idle(); cpl_status = 0; evt_stat = 0; evt_cause = 0; evt_seq = 0; rpt_dis = 0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        regs("R1", 0, 0, 0, 0, 0);

        // R5: completion with interrupt clear is reported
        do_cpl(8'h02);
        regs("R5", 'h93, 'h10, 0, 'h02, 1);
        tick();
        chk("R5", "xfer_clr one cycle", xfer_clr, 0);

        // R3: completion while pending is parked, visible state unchanged
        do_cpl(8'h05);
        regs("R3", 'h93, 'h10, 0, 'h02, 0);

        // R2: read cycle shows old cause; R4: replay of parked completion
        cause_rd = 1;
        chk("R2", "cause during read", cause, 'h10);
        tick();
        regs("R4", 'h93, 'h10, 0, 'h05, 1);

        // R2/R4: next read clears, no second replay
        do_read();
        regs("R2", 'h03, 0, 4, 'h05, 0);
        // R1: clearing an already clear pending bit keeps irq low
        do_read();
        chk("R1", "irq stays low", irq, 0);

        // R6: bus reset over suppress bit and prior interrupt level
        for (int rd = 0; rd < 2; rd++) begin
            for (int pre = 0; pre < 2; pre++) begin
                if (pre != 0) seldis_cmd = 1; else cause_rd = 1;
                tick();
                rpt_dis = rd[0]; busrst_cmd = 1; tick();
                chk("R6", "cause", cause, 'h80);
                chk("R6", "irq", irq, (pre != 0 || rd == 0) ? 1 : 0);
            end
        end
        rpt_dis = 0;

        // R7: selection commands
        do_read();
        selen_cmd = 1; tick();
        chk("R7", "enable cause", cause, 0); chk("R7", "enable irq low", irq, 0);
        evt_load = 1; evt_cause = 8'h44; tick();
        seldis_cmd = 1; tick();
        chk("R7", "disable cause", cause, 0); chk("R7", "disable irq", irq, 1);
        seldis_cmd = 1; tick();
        chk("R1", "raise when set", irq, 1);
        evt_load = 1; evt_cause = 8'h44; evt_raise = 0; tick();
        selen_cmd = 1; tick();
        chk("R7", "enable cause hi", cause, 0); chk("R7", "enable keeps irq", irq, 1);

        // R9: event load sweep
        for (int r = 0; r < 2; r++) begin
            for (int k = 0; k < 8; k++) begin
                do_read();
                evt_load = 1; evt_raise = r[0];
                evt_stat = 7'((k * 13) & 'h7f); evt_cause = 8'(1 << k); evt_seq = 3'(k);
                tick();
                chk("R9", "status", status, (r << 7) | ((k * 13) & 'h7f));
                chk("R9", "cause", cause, 1 << k);
                chk("R9", "seq", seq, k);
            end
        end

        // R8: read and completion together, nothing parked
        cause_rd = 1; cpl_req = 1; cpl_status = 8'h3C; tick();
        regs("R8", 'h93, 'h10, 0, 'h3C, 1);

        // R8: read and completion together with a parked entry
        do_cpl(8'hA1);
        regs("R3", 'h93, 'h10, 0, 'h3C, 0);
        cause_rd = 1; cpl_req = 1; cpl_status = 8'hB2; tick();
        regs("R8", 'h93, 'h10, 0, 'hA1, 1);
        do_read();
        regs("R8", 'h93, 'h10, 0, 'hB2, 1);
        do_read();
        regs("R4", 'h03, 0, 4, 'hB2, 0);

        // R5: completion byte sweep
        for (int i = 0; i < 16; i++) begin
            do_cpl(8'(i * 17));
            regs("R5", 'h93, 'h10, 0, i * 17, 1);
            do_read();
        end

        // R1: reset drops a parked completion
        do_cpl(8'h11);
        do_cpl(8'h22);
        rst_n = 0; tick(); tick(); rst_n = 1;
        regs("R1", 0, 0, 0, 0, 0);
        do_read();
        regs("R1", 0, 0, 4, 0, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule